// File: doc/BRIEF.md
# Banked GPIO Edge-Interrupt Register File

This block gives a host a byte-wide register window onto 24 general-purpose pins, organised as three banks of eight. Line n lives at bit (n mod 8) of bank (n div 8). Bank 0 is the least significant bank, bank 1 the centre bank and bank 2 the most significant bank. Outputs are driven by writing ones into a set register or a clear register, so no read-modify-write is needed. A direction register decides which pins drive. Every pin input passes through a two-flop synchronizer. The synchronized level can always be read back, whatever the pin's direction.

Each pin can watch for rising edges, falling edges or both. An enabled edge records a bit in an edge-detect status register. If the pin's interrupt enable is also set, the edge records a bit in an interrupt status register as well. The single active-high interrupt output is the OR of the interrupt status bits whose enables are set. Both status registers are cleared by writing ones back to them. If a new edge arrives in the same cycle as the clear, the status bit stays set. There is no level-sensitive mode.

Top module: `gpio_edge_irq_regs`

## Requirements
- R1: After reset, pinOe and pinOut are 0, irqOut is 0, rdData is 0, and every direction, enable and status register reads 0.
- R2: The address layout is fixed. Address bits [5:2] select a register group: 0 monitor, 1 set, 2 clear, 3 direction, 4 rising enable, 5 falling enable, 6 interrupt enable, 7 edge status, 8 interrupt status. Address bits [1:0] select the bank: offset 0 is bank 2, offset 1 is bank 1, offset 2 is bank 0. Line n maps to bit n mod 8 of bank n div 8.
- R3: Writing a 1 to a bit of the set group drives that bit of pinOut high. Writing a 1 to a bit of the clear group drives it low. Bits written as 0 do not change pinOut. Reading the set group returns the output latch, and reading the clear group returns 0.
- R4: pinOe equals the direction register, where 1 means output and 0 means input.
- R5: Reading the monitor group returns the pin levels after the two-flop synchronizer, whatever the pin directions. Writes to the monitor group have no effect.
- R6: Rising and falling enables are independent per pin, and setting both detects both edges. An enabled edge sets the pin's edge-status bit three clock edges after the pin input changes. An edge that is not enabled sets nothing.
- R7: An interrupt status bit is set only by an enabled edge while that pin's interrupt enable is 1. irqOut is the OR of the interrupt status bits ANDed with their interrupt enables. Clearing an interrupt enable drops irqOut but keeps the status bit.
- R8: Writing 1 to a bit of the edge-status or interrupt-status group clears that bit, and writing 0 leaves it unchanged. An edge in the same cycle as the clear wins, so the bit stays set.
- R9: rdData shows the addressed register in the cycle after rdEn and is 0 otherwise. Unmapped addresses (offset 3, or group 9 and above) read 0, and writes to them change nothing.
- R10: A pin held at a steady level sets no status bit, because detection is edge-only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| addr | input | 6 | Register address (group in [5:2], bank offset in [1:0]) |
| wrData | input | 8 | Write data byte |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| rdData | output | 8 | Read data, valid the cycle after rdEn |
| pinIn | input | 24 | Pin input levels |
| pinOut | output | 24 | Pin output latch |
| pinOe | output | 24 | Pin output enable (direction) |
| irqOut | output | 1 | Active-high interrupt |

## Verification
A vector table writes and reads back every writable group in different banks. This separates correct bank ordering from a reversed layout, and shows that a write to one bank leaves its neighbours alone. Set and clear writes with partly overlapping masks tell true write-one semantics apart from a plain overwrite. Pin waveforms are then applied with rising-only, falling-only and both-edge enables, and with the interrupt enable on and off. These show whether detection follows the enables and whether the two status registers are gated differently. The last tests hold a steady level, drop the interrupt enable while a status bit is pending, and line up an edge with its own clear in the same cycle, which separates edge-only, masked and edge-wins behaviour from the alternatives.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  parameter int BANK_W    = 8;
  parameter int NUM_BANKS = 3;
  parameter int GRP_W     = 4;

  localparam int NUM_PINS = BANK_W * NUM_BANKS;
  localparam int OFF_W    = $clog2(NUM_BANKS);
  localparam int ADDR_W   = GRP_W + OFF_W;

  typedef enum logic [GRP_W-1:0] {
    GRP_MON  = 4'd0,
    GRP_SET  = 4'd1,
    GRP_CLR  = 4'd2,
    GRP_DIR  = 4'd3,
    GRP_RISE = 4'd4,
    GRP_FALL = 4'd5,
    GRP_IE   = 4'd6,
    GRP_EDGE = 4'd7,
    GRP_IRQ  = 4'd8
  } grp_e;

  // Strobes from the decoder to the register datapath
  typedef struct packed {
    logic [NUM_BANKS-1:0] wrSet;
    logic [NUM_BANKS-1:0] wrClr;
    logic [NUM_BANKS-1:0] wrDir;
    logic [NUM_BANKS-1:0] wrRise;
    logic [NUM_BANKS-1:0] wrFall;
    logic [NUM_BANKS-1:0] wrIe;
    logic [NUM_BANKS-1:0] wrEdgeClr;
    logic [NUM_BANKS-1:0] wrIrqClr;
    logic                 rdValid;
    grp_e                 rdGroup;
    logic [OFF_W-1:0]     rdBank;
  } strobe_t;

  // Place a byte into each selected bank of a full-width pin vector
  function automatic logic [NUM_PINS-1:0] spreadByte(
      input logic [NUM_BANKS-1:0] sel,
      input logic [BANK_W-1:0]    data);
    logic [NUM_PINS-1:0] res;
    res = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (sel[b]) res[b*BANK_W +: BANK_W] = data;
    end
    return res;
  endfunction
endpackage

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
  parameter int WIDTH  = 24,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stage[0] <= '0;
    else       stage[0] <= din;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_chain
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stage[s] <= '0;
      else       stage[s] <= stage[s-1];
    end
  end

  assign dout = stage[STAGES-1];
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  output strobe_t           strb
);
  logic [GRP_W-1:0]     grpRaw;
  logic [OFF_W-1:0]     offset;
  logic [OFF_W-1:0]     bankIdx;
  logic [NUM_BANKS-1:0] bankHot;
  logic                 offOk;
  logic                 grpOk;

  assign grpRaw  = addr[ADDR_W-1 -: GRP_W];
  assign offset  = addr[OFF_W-1:0];
  assign offOk   = int'(offset) < NUM_BANKS;
  assign grpOk   = grpRaw <= GRP_IRQ;
  // Most significant bank sits at the lowest offset
  assign bankIdx = OFF_W'(NUM_BANKS - 1) - offset;
  assign bankHot = NUM_BANKS'(1) << bankIdx;

  always_comb begin
    strb         = '0;
    strb.rdBank  = bankIdx;
    strb.rdGroup = grpOk ? grp_e'(grpRaw) : GRP_MON;
    strb.rdValid = rdEn && offOk && grpOk;
    if (wrEn && offOk && grpOk) begin
      case (grp_e'(grpRaw))
        GRP_SET:  strb.wrSet     = bankHot;
        GRP_CLR:  strb.wrClr     = bankHot;
        GRP_DIR:  strb.wrDir     = bankHot;
        GRP_RISE: strb.wrRise    = bankHot;
        GRP_FALL: strb.wrFall    = bankHot;
        GRP_IE:   strb.wrIe      = bankHot;
        GRP_EDGE: strb.wrEdgeClr = bankHot;
        GRP_IRQ:  strb.wrIrqClr  = bankHot;
        default:  ;
      endcase
    end
  end

  // R9: one bus write reaches at most one bank of one register
  assert_single_target_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrSet, strb.wrClr, strb.wrDir, strb.wrRise,
              strb.wrFall, strb.wrIe, strb.wrEdgeClr, strb.wrIrqClr}));

  // R9: the read select never points outside the bank range
  assert_read_bank_range_R9: assert property (@(posedge clk) disable iff (!rstN)
    strb.rdValid |-> (int'(strb.rdBank) < NUM_BANKS));
endmodule

// File: rtl/gpio_bank_datapath.sv
module gpio_bank_datapath
  import gpio_bank_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             strb,
  input  logic [BANK_W-1:0]   wrData,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [BANK_W-1:0]   rdData,
  output logic [NUM_PINS-1:0] pinOut,
  output logic [NUM_PINS-1:0] pinOe,
  output logic                irqOut
);
  logic [NUM_PINS-1:0] outLat, dirReg, riseEn, fallEn, ieReg;
  logic [NUM_PINS-1:0] edgeStat, irqStat;
  logic [NUM_PINS-1:0] pinSync, pinPrev;
  logic [NUM_PINS-1:0] riseSeen, fallSeen, hit;
  logic [NUM_PINS-1:0] setMask, clrMask, edgeClrMask, irqClrMask;
  logic [NUM_PINS-1:0] grpWord;
  logic [BANK_W-1:0]   rdSlice;

  gpio_bank_sync #(.WIDTH(NUM_PINS), .STAGES(2)) u_sync (
    .clk  (clk),
    .rstN (rstN),
    .din  (pinIn),
    .dout (pinSync)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pinPrev <= '0;
    else       pinPrev <= pinSync;
  end

  assign riseSeen = pinSync & ~pinPrev;
  assign fallSeen = ~pinSync & pinPrev;
  assign hit      = (riseSeen & riseEn) | (fallSeen & fallEn);

  assign setMask     = spreadByte(strb.wrSet, wrData);
  assign clrMask     = spreadByte(strb.wrClr, wrData);
  assign edgeClrMask = spreadByte(strb.wrEdgeClr, wrData);
  assign irqClrMask  = spreadByte(strb.wrIrqClr, wrData);

  // Plain read/write configuration registers, one instance per kind
  logic [NUM_BANKS-1:0] cfgSel  [4];
  logic [NUM_PINS-1:0]  cfgQ    [4];
  assign cfgSel[0] = strb.wrDir;
  assign cfgSel[1] = strb.wrRise;
  assign cfgSel[2] = strb.wrFall;
  assign cfgSel[3] = strb.wrIe;

  for (genvar k = 0; k < 4; k++) begin : g_cfg
    logic [NUM_PINS-1:0] keepMask;
    assign keepMask = ~spreadByte(cfgSel[k], '1);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) cfgQ[k] <= '0;
      else       cfgQ[k] <= (cfgQ[k] & keepMask) | spreadByte(cfgSel[k], wrData);
    end
  end

  assign dirReg = cfgQ[0];
  assign riseEn = cfgQ[1];
  assign fallEn = cfgQ[2];
  assign ieReg  = cfgQ[3];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outLat   <= '0;
      edgeStat <= '0;
      irqStat  <= '0;
    end else begin
      outLat   <= (outLat | setMask) & ~clrMask;
      // A new edge wins over a simultaneous clear
      edgeStat <= (edgeStat & ~edgeClrMask) | hit;
      irqStat  <= (irqStat & ~irqClrMask) | (hit & ieReg);
    end
  end

  always_comb begin
    case (strb.rdGroup)
      GRP_MON:  grpWord = pinSync;
      GRP_SET:  grpWord = outLat;
      GRP_DIR:  grpWord = dirReg;
      GRP_RISE: grpWord = riseEn;
      GRP_FALL: grpWord = fallEn;
      GRP_IE:   grpWord = ieReg;
      GRP_EDGE: grpWord = edgeStat;
      GRP_IRQ:  grpWord = irqStat;
      default:  grpWord = '0;
    endcase
  end

  assign rdSlice = grpWord[strb.rdBank*BANK_W +: BANK_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdData <= '0;
    else       rdData <= strb.rdValid ? rdSlice : '0;
  end

  assign pinOut = outLat;
  assign pinOe  = dirReg;
  assign irqOut = |(irqStat & ieReg);

  // R3: an output bit moves only under a set or clear write to it
  assert_out_needs_write_R3: assert property (@(posedge clk) disable iff (!rstN)
    ((outLat ^ $past(outLat)) & ~$past(setMask | clrMask)) == '0);

  // R6: a new edge-status bit needs an enable for that pin
  assert_edge_needs_enable_R6: assert property (@(posedge clk) disable iff (!rstN)
    ((edgeStat & ~$past(edgeStat)) & ~$past(riseEn | fallEn)) == '0);

  // R7: a new interrupt-status bit needs the pin's interrupt enable
  assert_irq_needs_ie_R7: assert property (@(posedge clk) disable iff (!rstN)
    ((irqStat & ~$past(irqStat)) & ~$past(ieReg)) == '0);

  // R8: a cleared bit with no competing edge is gone next cycle
  assert_w1c_clears_R8: assert property (@(posedge clk) disable iff (!rstN)
    ($past(irqClrMask & ~hit) & irqStat) == '0);
endmodule

// File: rtl/gpio_edge_irq_regs.sv
module gpio_edge_irq_regs
  import gpio_bank_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [BANK_W-1:0]   wrData,
  input  logic                wrEn,
  input  logic                rdEn,
  output logic [BANK_W-1:0]   rdData,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [NUM_PINS-1:0] pinOut,
  output logic [NUM_PINS-1:0] pinOe,
  output logic                irqOut
);
  strobe_t strb;

  gpio_bank_ctrl u_ctrl (
    .clk  (clk),
    .rstN (rstN),
    .addr (addr),
    .wrEn (wrEn),
    .rdEn (rdEn),
    .strb (strb)
  );

  gpio_bank_datapath u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .wrData (wrData),
    .pinIn  (pinIn),
    .rdData (rdData),
    .pinOut (pinOut),
    .pinOe  (pinOe),
    .irqOut (irqOut)
  );
endmodule

// File: tb/tb_gpio_edge_irq_regs.sv
module tb_gpio_edge_irq_regs;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [5:0]  addr = '0;
  logic [7:0]  wrData = '0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [7:0]  rdData;
  logic [23:0] pinIn = '0;
  logic [23:0] pinOut, pinOe;
  logic        irqOut;

  int checks = 0;
  int errors = 0;

  gpio_edge_irq_regs dut (
    .clk(clk), .rstN(rstN), .addr(addr), .wrData(wrData), .wrEn(wrEn),
    .rdEn(rdEn), .rdData(rdData), .pinIn(pinIn), .pinOut(pinOut),
    .pinOe(pinOe), .irqOut(irqOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Addresses: group*4 + offset, offset 0 = bank2, 2 = bank0
  localparam logic [5:0] A_MON2 = 6'd0,  A_MON0 = 6'd2;
  localparam logic [5:0] A_SET1 = 6'd5,  A_CLR1 = 6'd9;
  localparam logic [5:0] A_DIR2 = 6'd12, A_DIR1 = 6'd13;
  localparam logic [5:0] A_RISE0 = 6'd18, A_FALL1 = 6'd21, A_FALL0 = 6'd22;
  localparam logic [5:0] A_IE2 = 6'd24, A_IE0 = 6'd26;
  localparam logic [5:0] A_EDGE0 = 6'd30, A_IRQ0 = 6'd34;

  typedef struct packed {
    logic       isRead;
    logic [5:0] a;
    logic [7:0] d;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VEC [NV] = '{
    '{1'b0, A_DIR2,  8'hA5, 4'd4},
    '{1'b1, A_DIR2,  8'hA5, 4'd2},
    '{1'b1, A_DIR1,  8'h00, 4'd2},
    '{1'b0, A_RISE0, 8'h3C, 4'd6},
    '{1'b1, A_RISE0, 8'h3C, 4'd6},
    '{1'b0, A_FALL1, 8'h81, 4'd6},
    '{1'b1, A_FALL1, 8'h81, 4'd6},
    '{1'b0, A_IE2,   8'hFF, 4'd7},
    '{1'b1, A_IE2,   8'hFF, 4'd7},
    '{1'b0, A_SET1,  8'h0F, 4'd3},
    '{1'b1, A_SET1,  8'h0F, 4'd3},
    '{1'b0, A_CLR1,  8'h05, 4'd3},
    '{1'b1, A_SET1,  8'h0A, 4'd3},
    '{1'b1, A_CLR1,  8'h00, 4'd3},
    '{1'b0, 6'd15,   8'hFF, 4'd9},
    '{1'b1, 6'd15,   8'h00, 4'd9},
    '{1'b0, A_MON2,  8'hFF, 4'd5},
    '{1'b1, 6'd36,   8'h00, 4'd9}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic busRead(input logic [5:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
    d = rdData;
  endtask

  task automatic readCheck(input string tag, input logic [5:0] a, input logic [7:0] exp);
    logic [7:0] v;
    busRead(a, v);
    check(tag, 32'(v), 32'(exp));
  endtask

  task automatic setPins(input logic [23:0] v);
    @(negedge clk);
    pinIn = v;
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 pinOe", 32'(pinOe), 0);
    check("R1 pinOut", 32'(pinOut), 0);
    check("R1 irqOut", 32'(irqOut), 0);
    check("R1 rdData", 32'(rdData), 0);
    readCheck("R1 dir", A_DIR2, 8'h00);
    readCheck("R1 irq status", A_IRQ0, 8'h00);

    // Register table walk (R2 R3 R4 R5 R6 R7 R9)
    for (int i = 0; i < NV; i++) begin
      if (VEC[i].isRead)
        readCheck($sformatf("R%0d vector %0d", VEC[i].req, i), VEC[i].a, VEC[i].d);
      else
        busWrite(VEC[i].a, VEC[i].d);
    end
    check("R4 pinOe", 32'(pinOe), 32'h00A5_0000);
    check("R3 pinOut", 32'(pinOut), 32'h0000_0A00);

    busWrite(A_DIR2, 8'h00);
    busWrite(A_RISE0, 8'h00);
    busWrite(A_FALL1, 8'h00);
    busWrite(A_IE2, 8'h00);

    // R5 monitor and R2 line mapping, edges not enabled
    setPins(24'h80_0001);
    settle(2);
    readCheck("R5 monitor bank0", A_MON0, 8'h01);
    readCheck("R2 monitor bank2", A_MON2, 8'h80);
    readCheck("R6 no enable no edge", A_EDGE0, 8'h00);
    setPins(24'h00_0000);
    settle(4);

    // R6/R7 rising edge on line 0 with interrupt enable
    busWrite(A_RISE0, 8'h01);
    busWrite(A_IE0, 8'h01);
    setPins(24'h00_0001);
    settle(3);
    check("R7 irqOut after rise", 32'(irqOut), 1);
    readCheck("R6 edge status rise", A_EDGE0, 8'h01);
    readCheck("R7 irq status rise", A_IRQ0, 8'h01);

    // R8 write-one-to-clear
    busWrite(A_IRQ0, 8'h00);
    readCheck("R8 zero write keeps", A_IRQ0, 8'h01);
    busWrite(A_IRQ0, 8'h01);
    readCheck("R8 one write clears", A_IRQ0, 8'h00);
    check("R7 irqOut cleared", 32'(irqOut), 0);
    readCheck("R8 edge kept", A_EDGE0, 8'h01);
    busWrite(A_EDGE0, 8'h01);
    readCheck("R8 edge cleared", A_EDGE0, 8'h00);

    // R6 falling edge with only rising enabled
    setPins(24'h00_0000);
    settle(4);
    readCheck("R6 fall ignored", A_EDGE0, 8'h00);

    // R6/R7 falling-only line 1, no interrupt enable
    busWrite(A_FALL0, 8'h02);
    setPins(24'h00_0002);
    settle(4);
    readCheck("R6 rise ignored falling-only", A_EDGE0, 8'h00);
    setPins(24'h00_0000);
    settle(4);
    readCheck("R6 fall detected", A_EDGE0, 8'h02);
    readCheck("R7 no ie no irq", A_IRQ0, 8'h00);
    check("R7 irqOut low", 32'(irqOut), 0);

    // R6 both edges on line 2
    busWrite(A_RISE0, 8'h05);
    busWrite(A_FALL0, 8'h06);
    busWrite(A_EDGE0, 8'hFF);
    setPins(24'h00_0004);
    settle(4);
    readCheck("R6 both rise", A_EDGE0, 8'h04);
    busWrite(A_EDGE0, 8'hFF);
    setPins(24'h00_0000);
    settle(4);
    readCheck("R6 both fall", A_EDGE0, 8'h04);

    // R10 steady level
    setPins(24'h00_0004);
    settle(4);
    busWrite(A_EDGE0, 8'hFF);
    settle(20);
    readCheck("R10 level no status", A_EDGE0, 8'h00);

    // R8 edge colliding with its own clear
    busWrite(A_IE0, 8'h04);
    busWrite(A_IRQ0, 8'hFF);
    setPins(24'h00_0000);
    settle(4);
    readCheck("R8 pre-collision status", A_IRQ0, 8'h04);
    setPins(24'h00_0004);
    repeat (2) @(posedge clk);
    busWrite(A_IRQ0, 8'h04);
    readCheck("R8 edge wins over clear", A_IRQ0, 8'h04);

    // R7 interrupt enable masks output but keeps status
    check("R7 irqOut pending", 32'(irqOut), 1);
    busWrite(A_IE0, 8'h00);
    check("R7 irqOut masked", 32'(irqOut), 0);
    readCheck("R7 status kept when masked", A_IRQ0, 8'h04);
    busWrite(A_IRQ0, 8'h04);
    readCheck("R8 final clear", A_IRQ0, 8'h00);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule